// File: doc/BRIEF.md
# Descriptor-Polling Frame Routing Engine

This engine forwards frames between agents inside a gateway subsystem without
software on the path. Every frame sitting in the local data RAM is described by
one 64-bit descriptor. The descriptors are kept in per-source rings inside a
descriptor store. The engine visits the routing sources one after another. When
it finds a live descriptor at the head of a source's ring, it decodes the target
agent. It then hands that agent a transfer command carrying the frame's buffer
address, its byte length and the originating source. The frame data itself is
moved by the agents.

Receive traffic follows the same path. A peripheral agent first writes the frame
into data RAM, then stores its descriptor and raises the source's pending flag.
Descriptors whose target is the processor-side agent are not commanded. They are
copied into a small local queue that the processor-side agent drains at its own
pace. Software or agents fill the descriptor store through a plain write/read
port. The store has no reset, so every slot must be written to zero before any
source flag is raised.

Descriptor word layout, least significant bit first: bit 0 live flag, bits 4:1
target agent, bits 8:5 source id, bits 20:9 length in bytes, bits 36:21 buffer
address, bits 63:37 unused. The slot of ring entry `h` of source `s` is at store
address `s*QDEPTH + h`.

Top module: `frame_route_engine`

## Requirements
- R1: After synchronous reset, all `cmd_valid` bits are low and `cpu_q_valid` is low.
- R2: A live descriptor at the head of an enabled source with its flag high, targeting agent d below NDST, raises only `cmd_valid[d]` within NSRC+3 cycles. The command carries the descriptor's address (bits 36:21), length (bits 20:9) and source id (bits 8:5).
- R3: A command stays asserted with unchanged fields until `cmd_ack` of its agent. The descriptor's live bit (bit 0) still reads 1 while the command is waiting. After the acknowledge, the command drops and the live bit reads 0.
- R4: Each source keeps its own ring head, which advances by one slot per consumed descriptor. Successive descriptors of one source are therefore taken from consecutive slots.
- R5: Once an agent acknowledges a command, it counts as busy until `agent_done`. No new command goes to a busy agent, and a descriptor targeting it stays live in the store.
- R6: After each dispatch the poll pointer moves to the next source. When two sources both hold dispatchable work, two successive dispatches never come from the same source.
- R7: A source whose bit in `src_enable` is 0 is never polled. Its descriptor stays live and no command is issued for it until the bit is set again.
- R8: A descriptor whose target id equals CPU_ID (15) is copied whole into the local queue with no command issued, and its live bit is then cleared in the store.
- R9: While the local queue holds CPU_FIFO entries, a descriptor targeting CPU_ID stays live in the store. It is taken once the queue has room again.
- R10: A live descriptor whose target is neither below NDST nor CPU_ID is discarded. Its live bit is cleared and neither a command nor a queue entry results.
- R11: `ext_rdata` returns the store word at `ext_addr` one clock after the address is presented. A word written through `ext_we` reads back unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_enable | input | NSRC | Per-source polling enable mask |
| src_flag | input | NSRC | Per-source pending-descriptor flag |
| ext_we | input | 1 | Store write strobe |
| ext_addr | input | AW | Store word address |
| ext_wdata | input | 64 | Store write data |
| ext_rdata | output | 64 | Store read data, one cycle after address |
| cmd_valid | output | NDST | One-hot transfer command per agent |
| cmd_ack | input | NDST | Per-agent command acknowledge |
| agent_done | input | NDST | Per-agent transfer completion pulse |
| cmd_addr | output | 16 | Frame buffer address of the command |
| cmd_len | output | 12 | Frame length in bytes of the command |
| cmd_src | output | 4 | Source id of the command |
| cpu_q_valid | output | 1 | Local queue holds an entry |
| cpu_q_desc | output | 64 | Oldest descriptor in the local queue |
| cpu_q_pop | input | 1 | Remove the oldest local queue entry |

## Verification
A command appears at most NSRC+3 cycles after its source flag rises. It falls in
the cycle after the acknowledge edge, and the cleared live bit is visible at the
store port one cycle after its address is applied. Queue entries show up three
cycles after the poller reaches the source. The bench drives inputs and samples
outputs on the falling edge. For each outcome it either waits with a bounded
counter or observes over a fixed window of cycles, so a result that is late or
spurious is reported rather than missed.

// File: rtl/frt_pkg.sv
package frt_pkg;
  localparam int DESC_W = 64;

  typedef struct packed {
    logic [26:0] spare;
    logic [15:0] buf_addr;
    logic [11:0] byte_len;
    logic [3:0]  src_id;
    logic [3:0]  tgt;
    logic        live;
  } frt_desc_t;
endpackage

// File: rtl/frt_desc_ram.sv
module frt_desc_ram #(
  parameter int AW = 4,
  parameter int DW = 64
) (
  input  logic          clk,
  input  logic          eng_re,
  input  logic [AW-1:0] eng_raddr,
  output logic [DW-1:0] eng_rdata,
  input  logic          eng_we,
  input  logic [AW-1:0] eng_waddr,
  input  logic [DW-1:0] eng_wdata,
  input  logic          ext_we,
  input  logic [AW-1:0] ext_addr,
  input  logic [DW-1:0] ext_wdata,
  output logic [DW-1:0] ext_rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  // Host write is applied after the engine write-back, so it wins a collision.
  always_ff @(posedge clk) begin
    if (eng_we) mem[eng_waddr] <= eng_wdata;
    if (ext_we) mem[ext_addr]  <= ext_wdata;
    if (eng_re) eng_rdata      <= mem[eng_raddr];
    ext_rdata <= mem[ext_addr];
  end
endmodule

// File: rtl/frt_src_poller.sv
module frt_src_poller #(
  parameter int NSRC   = 4,
  parameter int QDEPTH = 4,
  localparam int SW = $clog2(NSRC),
  localparam int QW = $clog2(QDEPTH)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] src_enable,
  input  logic [NSRC-1:0] src_flag,
  input  logic            advance,
  input  logic            consume,
  output logic [SW-1:0]   ptr,
  output logic [QW-1:0]   head_q,
  output logic            hit
);
  logic [QW-1:0] head [NSRC];

  assign hit    = src_enable[ptr] & src_flag[ptr];
  assign head_q = head[ptr];

  always_ff @(posedge clk) begin
    if (rst)
      ptr <= '0;
    else if (advance)
      ptr <= (ptr == SW'(NSRC - 1)) ? '0 : ptr + 1'b1;
  end

  for (genvar g = 0; g < NSRC; g++) begin : g_head
    always_ff @(posedge clk) begin
      if (rst)
        head[g] <= '0;
      else if (consume && ptr == SW'(g))
        head[g] <= (head[g] == QW'(QDEPTH - 1)) ? '0 : head[g] + 1'b1;
    end
  end

  assert_poll_only_enabled_R7: assert property (@(posedge clk) disable iff (rst)
    consume |-> src_enable[ptr] || $past(src_enable[ptr]))
    else $error("descriptor consumed from a masked source");
endmodule

// File: rtl/frt_agent_busy.sv
module frt_agent_busy #(
  parameter int NDST = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NDST-1:0] cmd_valid,
  input  logic [NDST-1:0] cmd_ack,
  input  logic [NDST-1:0] agent_done,
  output logic [NDST-1:0] busy
);
  for (genvar g = 0; g < NDST; g++) begin : g_agent
    always_ff @(posedge clk) begin
      if (rst)
        busy[g] <= 1'b0;
      else if (cmd_valid[g] && cmd_ack[g])
        busy[g] <= 1'b1;
      else if (agent_done[g])
        busy[g] <= 1'b0;
    end

    assert_no_cmd_to_busy_R5: assert property (@(posedge clk) disable iff (rst)
      cmd_valid[g] |-> !busy[g])
      else $error("command raised toward an agent still busy");
  end
endmodule

// File: rtl/frt_cpu_fifo.sv
module frt_cpu_fifo #(
  parameter int DEPTH = 4,
  parameter int DW    = 64,
  localparam int PW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [DW-1:0] din,
  input  logic          pop,
  output logic          full,
  output logic          valid,
  output logic [DW-1:0] dout
);
  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [PW:0]   cnt;
  logic          do_pop;

  assign full   = (cnt == (PW+1)'(DEPTH));
  assign valid  = (cnt != '0);
  assign dout   = mem[rp];
  assign do_pop = pop && valid;

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push)   wp <= (wp == PW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (do_pop) rp <= (rp == PW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      cnt <= cnt + (PW+1)'(push) - (PW+1)'(do_pop);
    end
  end

  assert_fifo_no_overflow_R9: assert property (@(posedge clk) disable iff (rst)
    push |-> !full)
    else $error("local queue written while full");
endmodule

// File: rtl/frame_route_engine.sv
module frame_route_engine #(
  parameter int NSRC     = 4,
  parameter int QDEPTH   = 4,
  parameter int NDST     = 4,
  parameter int CPU_ID   = 15,
  parameter int CPU_FIFO = 4,
  localparam int SW  = $clog2(NSRC),
  localparam int QW  = $clog2(QDEPTH),
  localparam int AW  = SW + QW,
  localparam int DIW = (NDST > 1) ? $clog2(NDST) : 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] src_enable,
  input  logic [NSRC-1:0] src_flag,
  input  logic            ext_we,
  input  logic [AW-1:0]   ext_addr,
  input  logic [63:0]     ext_wdata,
  output logic [63:0]     ext_rdata,
  output logic [NDST-1:0] cmd_valid,
  input  logic [NDST-1:0] cmd_ack,
  input  logic [NDST-1:0] agent_done,
  output logic [15:0]     cmd_addr,
  output logic [11:0]     cmd_len,
  output logic [3:0]      cmd_src,
  output logic            cpu_q_valid,
  output logic [63:0]     cpu_q_desc,
  input  logic            cpu_q_pop
);
  import frt_pkg::*;

  typedef enum logic [1:0] {ST_POLL, ST_CHK, ST_CMD} st_t;

  st_t             st;
  logic [SW-1:0]   ptr;
  logic [QW-1:0]   head_q;
  logic            hit, advance, consume;
  logic            eng_re, eng_we, push, fifo_full;
  logic [63:0]     eng_rdata, eng_wdata;
  logic [AW-1:0]   slot_addr;
  logic [NDST-1:0] busy;
  logic [DIW-1:0]  cur_tgt;
  frt_desc_t       rdesc, cur_desc, cleared;
  logic            tgt_agent, tgt_cpu, start_cmd;

  assign slot_addr = {ptr, head_q};
  assign rdesc     = frt_desc_t'(eng_rdata);
  assign tgt_cpu   = (rdesc.tgt == 4'(CPU_ID));
  assign tgt_agent = !tgt_cpu && (int'(rdesc.tgt) < NDST);
  assign start_cmd = (st == ST_CHK) && rdesc.live && tgt_agent &&
                     !busy[rdesc.tgt[DIW-1:0]];

  frt_src_poller #(.NSRC(NSRC), .QDEPTH(QDEPTH)) u_poll (
    .clk, .rst, .src_enable, .src_flag,
    .advance, .consume, .ptr, .head_q, .hit
  );

  frt_desc_ram #(.AW(AW), .DW(64)) u_ram (
    .clk, .eng_re, .eng_raddr(slot_addr), .eng_rdata,
    .eng_we, .eng_waddr(slot_addr), .eng_wdata,
    .ext_we, .ext_addr, .ext_wdata, .ext_rdata
  );

  frt_agent_busy #(.NDST(NDST)) u_busy (
    .clk, .rst, .cmd_valid, .cmd_ack, .agent_done, .busy
  );

  frt_cpu_fifo #(.DEPTH(CPU_FIFO), .DW(64)) u_cpuq (
    .clk, .rst, .push, .din(eng_rdata), .pop(cpu_q_pop),
    .full(fifo_full), .valid(cpu_q_valid), .dout(cpu_q_desc)
  );

  always_comb begin
    advance   = 1'b0;
    consume   = 1'b0;
    eng_re    = 1'b0;
    eng_we    = 1'b0;
    push      = 1'b0;
    cleared   = rdesc;
    case (st)
      ST_POLL: begin
        if (hit) eng_re = 1'b1;
        else     advance = 1'b1;
      end
      ST_CHK: begin
        if (!rdesc.live) begin
          advance = 1'b1;
        end else if (tgt_cpu) begin
          advance = 1'b1;
          if (!fifo_full) begin
            push    = 1'b1;
            eng_we  = 1'b1;
            consume = 1'b1;
          end
        end else if (tgt_agent) begin
          advance = !start_cmd;
        end else begin
          advance = 1'b1;
          eng_we  = 1'b1;
          consume = 1'b1;
        end
      end
      ST_CMD: begin
        cleared = cur_desc;
        if (cmd_ack[cur_tgt]) begin
          advance = 1'b1;
          consume = 1'b1;
          eng_we  = 1'b1;
        end
      end
      default: ;
    endcase
    cleared.live = 1'b0;
    eng_wdata    = 64'(cleared);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_POLL;
      cmd_valid <= '0;
      cmd_addr  <= '0;
      cmd_len   <= '0;
      cmd_src   <= '0;
      cur_tgt   <= '0;
      cur_desc  <= '0;
    end else begin
      case (st)
        ST_POLL: if (hit) st <= ST_CHK;
        ST_CHK: begin
          st <= ST_POLL;
          if (start_cmd) begin
            st        <= ST_CMD;
            cmd_valid <= NDST'(1) << rdesc.tgt[DIW-1:0];
            cmd_addr  <= rdesc.buf_addr;
            cmd_len   <= rdesc.byte_len;
            cmd_src   <= rdesc.src_id;
            cur_tgt   <= rdesc.tgt[DIW-1:0];
            cur_desc  <= rdesc;
          end
        end
        ST_CMD: begin
          if (cmd_ack[cur_tgt]) begin
            cmd_valid <= '0;
            st        <= ST_POLL;
          end
        end
        default: st <= ST_POLL;
      endcase
    end
  end

  assert_cmd_onehot_R2: assert property (@(posedge clk) disable iff (rst)
    $onehot0(cmd_valid))
    else $error("more than one agent commanded");

  assert_cmd_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (|(cmd_valid & ~cmd_ack)) |=>
      (cmd_valid == $past(cmd_valid)) && $stable(cmd_addr) &&
      $stable(cmd_len) && $stable(cmd_src))
    else $error("command changed before acknowledge");

  assert_writeback_clears_R3: assert property (@(posedge clk) disable iff (rst)
    eng_we |-> !eng_wdata[0])
    else $error("engine write-back left the live bit set");

  assert_read_enabled_src_R7: assert property (@(posedge clk) disable iff (rst)
    eng_re |-> src_enable[ptr])
    else $error("masked source polled");

  assert_cpu_path_no_cmd_R8: assert property (@(posedge clk) disable iff (rst)
    push |=> (cmd_valid == '0))
    else $error("local queue push raised a command");
endmodule

// File: tb/frame_route_engine_tb.sv
module frame_route_engine_tb;
  localparam int NSRC = 4;
  localparam int QD   = 4;
  localparam int NDST = 4;
  localparam int AW   = 4;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [NSRC-1:0] src_enable = '1;
  logic [NSRC-1:0] src_flag = '0;
  logic            ext_we = 1'b0;
  logic [AW-1:0]   ext_addr = '0;
  logic [63:0]     ext_wdata = '0;
  logic [63:0]     ext_rdata;
  logic [NDST-1:0] cmd_valid;
  logic [NDST-1:0] cmd_ack = '0;
  logic [NDST-1:0] agent_done = '0;
  logic [15:0]     cmd_addr;
  logic [11:0]     cmd_len;
  logic [3:0]      cmd_src;
  logic            cpu_q_valid;
  logic [63:0]     cpu_q_desc;
  logic            cpu_q_pop = 1'b0;

  int checks = 0;
  int fails  = 0;
  int head [NSRC];

  always #2.5 clk = ~clk;

  frame_route_engine u_dut (
    .clk, .rst, .src_enable, .src_flag, .ext_we, .ext_addr, .ext_wdata,
    .ext_rdata, .cmd_valid, .cmd_ack, .agent_done, .cmd_addr, .cmd_len,
    .cmd_src, .cpu_q_valid, .cpu_q_desc, .cpu_q_pop
  );

  // fields: src[33:32] target[31:28] length[27:16] address[15:0]
  localparam logic [33:0] VEC [6] = '{
    {2'd0, 4'd0, 12'd64,   16'h0100},
    {2'd1, 4'd1, 12'd8,    16'h0480},
    {2'd2, 4'd2, 12'd1518, 16'h1000},
    {2'd3, 4'd3, 12'd0,    16'h2000},
    {2'd0, 4'd1, 12'd4095, 16'hFFFF},
    {2'd0, 4'd2, 12'd12,   16'h0040}
  };

  task automatic chk(input bit ok, input string tag,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] mk(int s, int d, int l, int a, bit v);
    return {27'd0, a[15:0], l[11:0], s[3:0], d[3:0], v};
  endfunction

  function automatic int slot(int s, int h);
    return s * QD + (h % QD);
  endfunction

  task automatic wr(input int a, input logic [63:0] w);
    @(negedge clk);
    ext_we = 1'b1; ext_addr = AW'(a); ext_wdata = w;
    @(negedge clk);
    ext_we = 1'b0;
  endtask

  task automatic rd(input int a, output logic [63:0] w);
    @(negedge clk);
    ext_addr = AW'(a);
    @(negedge clk);
    w = ext_rdata;
  endtask

  task automatic wait_cmd(input int d, output int lat);
    lat = 0;
    while (!cmd_valid[d] && lat < 60) begin
      @(negedge clk);
      lat++;
    end
  endtask

  task automatic pulse_ack(input int d);
    cmd_ack[d] = 1'b1;
    @(negedge clk);
    cmd_ack[d] = 1'b0;
  endtask

  task automatic pulse_done(input int d);
    agent_done[d] = 1'b1;
    @(negedge clk);
    agent_done[d] = 1'b0;
  endtask

  task automatic pop_one();
    cpu_q_pop = 1'b1;
    @(negedge clk);
    cpu_q_pop = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [63:0] w;
    int lat, cnt, first, other, dd;
    int ord [3];
    for (int i = 0; i < NSRC; i++) head[i] = 0;

    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(cmd_valid == '0, "R1 cmd_valid idle", 64'(cmd_valid), 0);
    chk(!cpu_q_valid, "R1 queue empty", 64'(cpu_q_valid), 0);

    for (int i = 0; i < NSRC * QD; i++) wr(i, 64'd0);

    // R11: store port round trip
    wr(slot(2, 1), 64'hDEAD_BEEF_0123_4566);
    rd(slot(2, 1), w);
    chk(w == 64'hDEAD_BEEF_0123_4566, "R11 readback", w, 64'hDEAD_BEEF_0123_4566);
    wr(slot(2, 1), 64'd0);

    // vector table: R2 R3 R4
    for (int i = 0; i < 6; i++) begin
      int s, d, l, a, sl;
      s = int'(VEC[i][33:32]); d = int'(VEC[i][31:28]);
      l = int'(VEC[i][27:16]); a = int'(VEC[i][15:0]);
      sl = slot(s, head[s]);
      wr(sl, mk(s, d, l, a, 1'b1));
      src_flag[s] = 1'b1;
      wait_cmd(d, lat);
      chk(lat <= NSRC + 3, "R2 latency", 64'(lat), 64'(NSRC + 3));
      chk(cmd_valid == NDST'(1 << d), "R2 onehot", 64'(cmd_valid), 64'(1 << d));
      chk(cmd_addr == 16'(a), "R2 R4 address", 64'(cmd_addr), 64'(a));
      chk(cmd_len == 12'(l), "R2 length", 64'(cmd_len), 64'(l));
      chk(cmd_src == 4'(s), "R2 source", 64'(cmd_src), 64'(s));
      repeat (3) @(negedge clk);
      chk(cmd_valid == NDST'(1 << d) && cmd_addr == 16'(a), "R3 held",
          64'(cmd_valid), 64'(1 << d));
      rd(sl, w);
      chk(w[0] == 1'b1, "R3 live before ack", 64'(w[0]), 1);
      pulse_ack(d);
      src_flag[s] = 1'b0;
      chk(cmd_valid == '0, "R3 drop after ack", 64'(cmd_valid), 0);
      head[s]++;
      rd(sl, w);
      chk(w[0] == 1'b0, "R3 cleared after ack", 64'(w[0]), 0);
      pulse_done(d);
    end

    // R5: busy agent skipped
    wr(slot(0, head[0]), mk(0, 1, 20, 16'h0500, 1'b1));
    wr(slot(1, head[1]), mk(1, 1, 30, 16'h0600, 1'b1));
    src_flag[0] = 1'b1; src_flag[1] = 1'b1;
    wait_cmd(1, lat);
    first = int'(cmd_src);
    other = 1 - first;
    pulse_ack(1);
    src_flag[first] = 1'b0;
    head[first]++;
    cnt = 0;
    for (int k = 0; k < 12; k++) begin
      @(negedge clk);
      if (cmd_valid != '0) cnt++;
    end
    chk(cnt == 0, "R5 no command while busy", 64'(cnt), 0);
    rd(slot(other, head[other]), w);
    chk(w[0] == 1'b1, "R5 descriptor pending", 64'(w[0]), 1);
    pulse_done(1);
    wait_cmd(1, lat);
    chk(lat < 60 && cmd_src == 4'(other), "R5 resumes after done",
        64'(cmd_src), 64'(other));
    pulse_ack(1);
    src_flag[other] = 1'b0;
    head[other]++;
    pulse_done(1);

    // R6: round robin between two busy sources
    wr(slot(0, head[0]),     mk(0, 0, 40, 16'h0700, 1'b1));
    wr(slot(0, head[0] + 1), mk(0, 2, 41, 16'h0800, 1'b1));
    wr(slot(1, head[1]),     mk(1, 3, 42, 16'h0900, 1'b1));
    src_flag[0] = 1'b1; src_flag[1] = 1'b1;
    cnt = 0;
    for (int n = 0; n < 3; n++) begin
      lat = 0;
      while (cmd_valid == '0 && lat < 60) begin
        @(negedge clk);
        lat++;
      end
      if (lat < 60) cnt++;
      ord[n] = int'(cmd_src);
      dd = 0;
      for (int b = 0; b < NDST; b++) if (cmd_valid[b]) dd = b;
      pulse_ack(dd);
      pulse_done(dd);
    end
    src_flag[0] = 1'b0; src_flag[1] = 1'b0;
    head[0] += 2; head[1] += 1;
    chk(cnt == 3, "R6 all dispatched", 64'(cnt), 3);
    chk(ord[0] != ord[1], "R6 alternation", 64'(ord[1]), 64'(1 - ord[0]));

    // R7: masked source
    src_enable = 4'b1011;
    wr(slot(2, head[2]), mk(2, 0, 50, 16'h0A00, 1'b1));
    src_flag[2] = 1'b1;
    cnt = 0;
    for (int k = 0; k < 30; k++) begin
      @(negedge clk);
      if (cmd_valid != '0) cnt++;
    end
    chk(cnt == 0, "R7 masked no command", 64'(cnt), 0);
    rd(slot(2, head[2]), w);
    chk(w[0] == 1'b1, "R7 masked stays live", 64'(w[0]), 1);
    src_enable = '1;
    wait_cmd(0, lat);
    chk(lat < 60 && cmd_addr == 16'h0A00, "R7 served once enabled",
        64'(cmd_addr), 64'h0A00);
    pulse_ack(0);
    src_flag[2] = 1'b0;
    head[2]++;
    pulse_done(0);

    // R8: processor-bound descriptor
    wr(slot(3, head[3]), mk(3, 15, 100, 16'h3000, 1'b1));
    src_flag[3] = 1'b1;
    cnt = 0; lat = 0;
    while (!cpu_q_valid && lat < 60) begin
      @(negedge clk);
      lat++;
      if (cmd_valid != '0) cnt++;
    end
    src_flag[3] = 1'b0;
    chk(cpu_q_desc == mk(3, 15, 100, 16'h3000, 1'b1), "R8 queue word",
        cpu_q_desc, mk(3, 15, 100, 16'h3000, 1'b1));
    chk(cnt == 0, "R8 no command", 64'(cnt), 0);
    rd(slot(3, head[3]), w);
    chk(w[0] == 1'b0, "R8 cleared", 64'(w[0]), 0);
    head[3]++;
    pop_one();
    chk(!cpu_q_valid, "R8 queue drained", 64'(cpu_q_valid), 0);

    // R9: queue full back-pressure
    for (int k = 0; k < 4; k++)
      wr(slot(3, head[3] + k), mk(3, 15, 10 + k, 16'h4000 + k, 1'b1));
    wr(slot(1, head[1]), mk(1, 15, 99, 16'h5000, 1'b1));
    src_flag[3] = 1'b1; src_flag[1] = 1'b1;
    repeat (40) @(negedge clk);
    chk(cpu_q_valid, "R9 queue holds entries", 64'(cpu_q_valid), 1);
    cnt = 0;
    for (int k = 0; k < 4; k++) begin
      rd(slot(3, head[3] + k), w);
      if (w[0]) cnt++;
    end
    rd(slot(1, head[1]), w);
    if (w[0]) cnt++;
    chk(cnt == 1, "R9 one left pending while full", 64'(cnt), 1);
    pop_one();
    repeat (20) @(negedge clk);
    cnt = 0;
    for (int k = 0; k < 4; k++) begin
      rd(slot(3, head[3] + k), w);
      if (w[0]) cnt++;
    end
    rd(slot(1, head[1]), w);
    if (w[0]) cnt++;
    chk(cnt == 0, "R9 taken after space", 64'(cnt), 0);
    src_flag[3] = 1'b0; src_flag[1] = 1'b0;
    head[3] += 4; head[1] += 1;
    for (int k = 0; k < 4; k++) pop_one();
    chk(!cpu_q_valid, "R9 queue empty at end", 64'(cpu_q_valid), 0);

    // R10: unknown target discarded
    wr(slot(0, head[0]), mk(0, 7, 60, 16'h6000, 1'b1));
    src_flag[0] = 1'b1;
    cnt = 0;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (cmd_valid != '0 || cpu_q_valid) cnt++;
    end
    src_flag[0] = 1'b0;
    chk(cnt == 0, "R10 no output", 64'(cnt), 0);
    rd(slot(0, head[0]), w);
    chk(w[0] == 1'b0, "R10 discarded", 64'(w[0]), 0);
    head[0]++;

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule